// File: doc/BRIEF.md
# Wrap-Aware Code Phase Interpolator

This block turns a pair of host-supplied waypoints into a code phase for every sample time step. Each waypoint pairs a tick count with a phase that only records the position inside one code period of 1023 chips. So the straight line between two waypoints may cross the period boundary. Each segment arrives with two crossing flags. The block uses them, together with the borrow of the plain phase subtraction, to pick between the plain phase difference and one of two wrap-adjusted differences. These are all computed side by side.

A segment load starts a sequential division of the chosen difference by the segment duration. The result is a signed per-tick slope. While the division runs, both input channels hold ready low. After that, every accepted time step costs one multiply-accumulate from the segment start. The result is folded back into the code period and appears two cycles later. The load and step channels use valid/ready. A producer must hold its payload stable while valid is high and ready is low, and a transfer happens on a rising edge where both are high. The output channel has no ready, so the consumer must take every beat.

Top module: `cp_interp`

## Requirements
- R1: After reset, out_valid and ld_err are low, out_phase is zero, and ld_ready and step_ready are high.
- R2: Phases are unsigned Q10.16 chips in [0, 1023·2^16). With no crossing flag in effect, the output for step time t equals start + (end − start)·(t − t_start)/(t_end − t_start), within 4 LSB. This holds for both rising and falling segments.
- R3: When cross_up is set and end < start, the difference used is end + 1023 chips − start, so the phase keeps advancing across the boundary.
- R4: When cross_down is set and end > start, the difference used is end − 1023 chips − start, so the phase keeps retreating across the boundary.
- R5: A crossing flag that disagrees with the borrow of end − start is ignored, and the plain difference is used. This covers cross_up with end ≥ start, and cross_down with end ≤ start.
- R6: Every output lies in [0, 1023·2^16). A result at or above the period has the period subtracted, and a negative result has it added.
- R7: A load is invalid if t_end ≤ t_start, if both flags are set, or if either phase is at or above 1023 chips. An accepted invalid load raises ld_err for exactly the following cycle and leaves the previous segment in force.
- R8: A valid load drops ld_ready and step_ready in the next cycle. Both return high within 45 cycles (one per quotient bit plus margin).
- R9: out_valid rises exactly two cycles after each accepted step and never otherwise. A step offered while step_ready is low is not taken.
- R10: A step at t = t_start returns the start phase exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Segment load offered |
| ld_ready | output | 1 | Segment load can be taken |
| ld_phase_start | input | 26 | Start phase, Q10.16 chips |
| ld_phase_end | input | 26 | End phase, Q10.16 chips |
| ld_time_start | input | 32 | Start tick |
| ld_time_end | input | 32 | End tick |
| ld_cross_up | input | 1 | Segment advances into the next code period |
| ld_cross_down | input | 1 | Segment falls back into the previous code period |
| ld_err | output | 1 | One-cycle pulse after an invalid load |
| step_valid | input | 1 | Time step offered |
| step_ready | output | 1 | Time step can be taken |
| step_time | input | 32 | Tick of the requested sample |
| out_valid | output | 1 | Interpolated phase present |
| out_phase | output | 26 | Interpolated phase, Q10.16 chips |

## Verification
The properties assume that both producers drive known levels from the first edge, and that the output consumer never stalls. The range property on out_phase further assumes that every step time lies between the active segment's start and end ticks, because extrapolation may leave more than one period to fold. The directed stimulus only issues steps inside the loaded segment's window, after ld_ready has returned. The one exception is the stall scenario, where steps are offered on purpose while ready is low.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int CPI_INT_W      = 10;
  localparam int CPI_FRAC_W     = 16;
  localparam int CPI_PH_W       = CPI_INT_W + CPI_FRAC_W;
  localparam int CPI_TIME_W     = 32;
  localparam int CPI_CODE_CHIPS = 1023;
  localparam int CPI_SLOPE_XF   = 16;
  localparam logic [CPI_PH_W-1:0] CPI_MOD =
    CPI_PH_W'(CPI_CODE_CHIPS) << CPI_FRAC_W;

  typedef enum logic [1:0] {
    DSEL_PLAIN = 2'd0,
    DSEL_FWD   = 2'd1,
    DSEL_BWD   = 2'd2
  } diff_sel_e;
endpackage

// File: rtl/cpi_wrap_diff.sv
module cpi_wrap_diff
  import cpi_pkg::*;
#(
  parameter int              PH_W = CPI_PH_W,
  parameter logic [PH_W-1:0] MOD  = CPI_MOD
) (
  input  logic [PH_W-1:0] ph_start,
  input  logic [PH_W-1:0] ph_end,
  input  logic            cross_up,
  input  logic            cross_down,
  output logic [PH_W-1:0] diff_mag,
  output logic            diff_neg
);
  localparam int D_W = PH_W + 2;

  logic [PH_W:0]          raw_sub;
  logic                   borrow;
  logic signed [D_W-1:0]  s_start, s_end, s_mod;
  logic signed [D_W-1:0]  d_plain, d_fwd, d_bwd, d_pick, d_abs;
  diff_sel_e              sel;
  logic                   unused_abs_hi;

  // plain subtraction supplies the borrow used for selection
  assign raw_sub = {1'b0, ph_end} - {1'b0, ph_start};
  assign borrow  = raw_sub[PH_W];

  assign s_start = $signed({2'b00, ph_start});
  assign s_end   = $signed({2'b00, ph_end});
  assign s_mod   = $signed({2'b00, MOD});

  // all three candidates exist at all times
  assign d_plain = s_end - s_start;
  assign d_fwd   = s_end + s_mod - s_start;
  assign d_bwd   = s_end - s_mod - s_start;

  always_comb begin
    if (cross_up && borrow)
      sel = DSEL_FWD;
    else if (cross_down && !borrow && (ph_end != ph_start))
      sel = DSEL_BWD;
    else
      sel = DSEL_PLAIN;
  end

  always_comb begin
    unique case (sel)
      DSEL_FWD: d_pick = d_fwd;
      DSEL_BWD: d_pick = d_bwd;
      default:  d_pick = d_plain;
    endcase
  end

  assign diff_neg      = d_pick[D_W-1];
  assign d_abs         = diff_neg ? -d_pick : d_pick;
  assign diff_mag      = d_abs[PH_W-1:0];
  assign unused_abs_hi = ^d_abs[D_W-1:PH_W];
endmodule

// File: rtl/cpi_seq_div.sv
module cpi_seq_div #(
  parameter int NUM_W = 42,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             fits;

  // restoring step: bring down one dividend bit, try the divisor
  assign shifted = {rem_q, acc_q[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign fits    = !trial[DEN_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      den_q <= '0;
      rem_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        den_q <= den;
        rem_q <= '0;
        acc_q <= num;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        acc_q <= {acc_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = acc_q;
endmodule

// File: rtl/cpi_step_mac.sv
module cpi_step_mac #(
  parameter int              PH_W   = 26,
  parameter int              TIME_W = 32,
  parameter int              SL_W   = 43,
  parameter int              XF     = 16,
  parameter logic [PH_W-1:0] MOD    = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_fire,
  input  logic [TIME_W-1:0]      in_time,
  input  logic [TIME_W-1:0]      base_time,
  input  logic [PH_W-1:0]        base_phase,
  input  logic signed [SL_W-1:0] slope,
  output logic                   out_valid,
  output logic [PH_W-1:0]        out_phase
);
  localparam int PR_W = SL_W + TIME_W + 1;

  logic [TIME_W-1:0]      elapsed;
  logic signed [PR_W-1:0] prod_d, prod_q;
  logic [PH_W-1:0]        base_q;
  logic                   v1_q;

  logic signed [PR_W-1:0] base_sc, mod_sc, sum_sc, red_sc;
  logic                   unused_red;

  assign elapsed = in_time - base_time;
  assign prod_d  = $signed(slope) * $signed({1'b0, elapsed});

  // stage 1: slope times elapsed ticks, base captured alongside
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      base_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= in_fire;
      if (in_fire) begin
        prod_q <= prod_d;
        base_q <= base_phase;
      end
    end
  end

  // stage 2: accumulate onto the base in the slope's scale, fold once
  assign base_sc = $signed({{(PR_W-PH_W-XF){1'b0}}, base_q, {XF{1'b0}}});
  assign mod_sc  = $signed({{(PR_W-PH_W-XF){1'b0}}, MOD, {XF{1'b0}}});
  assign sum_sc  = base_sc + prod_q;

  always_comb begin
    if (sum_sc < 0)
      red_sc = sum_sc + mod_sc;
    else if (sum_sc >= mod_sc)
      red_sc = sum_sc - mod_sc;
    else
      red_sc = sum_sc;
  end

  assign unused_red = ^{red_sc[PR_W-1:XF+PH_W], red_sc[XF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_phase <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q)
        out_phase <= red_sc[XF+PH_W-1:XF];
    end
  end
endmodule

// File: rtl/cp_interp.sv
module cp_interp
  import cpi_pkg::*;
#(
  parameter int              PH_W     = CPI_PH_W,
  parameter int              TIME_W   = CPI_TIME_W,
  parameter int              SLOPE_XF = CPI_SLOPE_XF,
  parameter logic [PH_W-1:0] MOD      = CPI_MOD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [PH_W-1:0]   ld_phase_start,
  input  logic [PH_W-1:0]   ld_phase_end,
  input  logic [TIME_W-1:0] ld_time_start,
  input  logic [TIME_W-1:0] ld_time_end,
  input  logic              ld_cross_up,
  input  logic              ld_cross_down,
  output logic              ld_err,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic [TIME_W-1:0] step_time,
  output logic              out_valid,
  output logic [PH_W-1:0]   out_phase
);
  localparam int NUM_W = PH_W + SLOPE_XF;
  localparam int SL_W  = NUM_W + 1;

  logic                   seg_busy;
  logic                   err_q;
  logic                   neg_pend;
  logic [PH_W-1:0]        base_ph;
  logic [TIME_W-1:0]      base_t;
  logic signed [SL_W-1:0] slope_q;

  logic                   ld_fire, load_bad, load_go, step_fire;
  logic [TIME_W-1:0]      duration;
  logic [PH_W-1:0]        d_mag;
  logic                   d_neg;
  logic                   div_done;
  logic [NUM_W-1:0]       div_quo;

  assign ld_ready   = !seg_busy;
  assign step_ready = !seg_busy;
  assign ld_fire    = ld_valid && ld_ready;
  assign step_fire  = step_valid && step_ready;
  assign duration   = ld_time_end - ld_time_start;

  assign load_bad = (ld_time_end <= ld_time_start)
                 || (ld_cross_up && ld_cross_down)
                 || (ld_phase_start >= MOD)
                 || (ld_phase_end >= MOD);
  assign load_go  = ld_fire && !load_bad;

  cpi_wrap_diff #(
    .PH_W (PH_W),
    .MOD  (MOD)
  ) u_diff (
    .ph_start   (ld_phase_start),
    .ph_end     (ld_phase_end),
    .cross_up   (ld_cross_up),
    .cross_down (ld_cross_down),
    .diff_mag   (d_mag),
    .diff_neg   (d_neg)
  );

  cpi_seq_div #(
    .NUM_W (NUM_W),
    .DEN_W (TIME_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (load_go),
    .num   ({d_mag, {SLOPE_XF{1'b0}}}),
    .den   (duration),
    .done  (div_done),
    .quo   (div_quo)
  );

  // segment registers: base commits on acceptance, slope on division end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_busy <= 1'b0;
      err_q    <= 1'b0;
      neg_pend <= 1'b0;
      base_ph  <= '0;
      base_t   <= '0;
      slope_q  <= '0;
    end else begin
      err_q <= ld_fire && load_bad;
      if (load_go) begin
        seg_busy <= 1'b1;
        neg_pend <= d_neg;
        base_ph  <= ld_phase_start;
        base_t   <= ld_time_start;
      end else if (div_done) begin
        seg_busy <= 1'b0;
        slope_q  <= neg_pend ? -$signed({1'b0, div_quo})
                             :  $signed({1'b0, div_quo});
      end
    end
  end

  assign ld_err = err_q;

  cpi_step_mac #(
    .PH_W   (PH_W),
    .TIME_W (TIME_W),
    .SL_W   (SL_W),
    .XF     (SLOPE_XF),
    .MOD    (MOD)
  ) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (step_fire),
    .in_time    (step_time),
    .base_time  (base_t),
    .base_phase (base_ph),
    .slope      (slope_q),
    .out_valid  (out_valid),
    .out_phase  (out_phase)
  );
endmodule

// File: rtl/cp_interp_chk.sv
module cp_interp_chk
  import cpi_pkg::*;
#(
  parameter int              PH_W   = CPI_PH_W,
  parameter int              TIME_W = CPI_TIME_W,
  parameter logic [PH_W-1:0] MOD    = CPI_MOD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [PH_W-1:0]   ld_phase_start,
  input logic [PH_W-1:0]   ld_phase_end,
  input logic [TIME_W-1:0] ld_time_start,
  input logic [TIME_W-1:0] ld_time_end,
  input logic              ld_cross_up,
  input logic              ld_cross_down,
  input logic              ld_err,
  input logic              step_valid,
  input logic              step_ready,
  input logic              out_valid,
  input logic [PH_W-1:0]   out_phase
);
  logic good_load;
  assign good_load = ld_valid && ld_ready
                  && (ld_time_end > ld_time_start)
                  && !(ld_cross_up && ld_cross_down)
                  && (ld_phase_start < MOD) && (ld_phase_end < MOD);

  assert_phase_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_phase < MOD));

  assert_bad_time_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && (ld_time_end <= ld_time_start)) |=> ld_err);

  assert_err_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> ($past(ld_valid && ld_ready) && ld_ready));

  assert_load_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    good_load |=> (!ld_ready && !step_ready && !ld_err));

  assert_two_cycle_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(step_valid && step_ready, 2));
endmodule

bind cp_interp cp_interp_chk #(
  .PH_W   (PH_W),
  .TIME_W (TIME_W),
  .MOD    (MOD)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ld_valid       (ld_valid),
  .ld_ready       (ld_ready),
  .ld_phase_start (ld_phase_start),
  .ld_phase_end   (ld_phase_end),
  .ld_time_start  (ld_time_start),
  .ld_time_end    (ld_time_end),
  .ld_cross_up    (ld_cross_up),
  .ld_cross_down  (ld_cross_down),
  .ld_err         (ld_err),
  .step_valid     (step_valid),
  .step_ready     (step_ready),
  .out_valid      (out_valid),
  .out_phase      (out_phase)
);

// File: tb/cp_interp_tb_top.sv
`timescale 1ns/1ps
module cp_interp_tb_top;
  localparam longint MODL  = 64'd1023 * 64'd65536;
  localparam int     LIMIT = 45;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [25:0] ld_phase_start = '0;
  logic [25:0] ld_phase_end = '0;
  logic [31:0] ld_time_start = '0;
  logic [31:0] ld_time_end = '0;
  logic        ld_cross_up = 1'b0;
  logic        ld_cross_down = 1'b0;
  logic        ld_err;
  logic        step_valid = 1'b0;
  logic        step_ready;
  logic [31:0] step_time = '0;
  logic        out_valid;
  logic [25:0] out_phase;

  int n_chk = 0;
  int n_fail = 0;

  real    s_ps, s_pe;
  longint s_ts, s_te;
  bit     s_up, s_dn;

  always #2.5 clk = ~clk;

  cp_interp dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_phase_start(ld_phase_start), .ld_phase_end(ld_phase_end),
    .ld_time_start(ld_time_start), .ld_time_end(ld_time_end),
    .ld_cross_up(ld_cross_up), .ld_cross_down(ld_cross_down),
    .ld_err(ld_err),
    .step_valid(step_valid), .step_ready(step_ready), .step_time(step_time),
    .out_valid(out_valid), .out_phase(out_phase)
  );

  function automatic longint c2l(real chips);
    return longint'(chips * 65536.0);
  endfunction

  task automatic chk(bit ok, string req, string what, longint got, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // modular reference in chips, flag rule taken from R3/R4/R5
  function automatic real ref_phase(longint t);
    real d, r;
    d = s_pe - s_ps;
    if (s_up && s_pe < s_ps) d = d + 1023.0;
    else if (s_dn && s_pe > s_ps) d = d - 1023.0;
    r = s_ps + d * real'(t - s_ts) / real'(s_te - s_ts);
    while (r < 0.0) r = r + 1023.0;
    while (r >= 1023.0) r = r - 1023.0;
    return r;
  endfunction

  task automatic load_seg(real ps, real pe, longint ts, longint te,
                          bit up, bit dn, bit exp_err, string req);
    int n;
    @(negedge clk);
    chk(ld_ready, req, "ld_ready before load", longint'(ld_ready), 1);
    ld_valid = 1'b1;
    ld_phase_start = 26'(c2l(ps));
    ld_phase_end = 26'(c2l(pe));
    ld_time_start = 32'(ts);
    ld_time_end = 32'(te);
    ld_cross_up = up;
    ld_cross_down = dn;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    chk(ld_err == exp_err, req, "ld_err after load", longint'(ld_err), longint'(exp_err));
    if (!exp_err) begin
      // R8: both channels stall while the slope is formed
      chk(!ld_ready && !step_ready, "R8", "ready low after load",
          longint'({ld_ready, step_ready}), 0);
      n = 0;
      while (!ld_ready && n < 200) begin
        @(negedge clk);
        n++;
      end
      chk(n <= LIMIT, "R8", "cycles until ready", n, LIMIT);
      s_ps = real'(c2l(ps)) / 65536.0;
      s_pe = real'(c2l(pe)) / 65536.0;
      s_ts = ts; s_te = te; s_up = up; s_dn = dn;
    end else begin
      @(negedge clk);
      chk(!ld_err, "R7", "ld_err one cycle only", longint'(ld_err), 0);
    end
  endtask

  task automatic step_at(longint t, string req, bit exact);
    longint expl, d;
    @(negedge clk);
    step_valid = 1'b1;
    step_time = 32'(t);
    @(posedge clk);
    @(negedge clk);
    step_valid = 1'b0;
    chk(!out_valid, "R9", "out_valid one cycle after step", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid, "R9", "out_valid two cycles after step", longint'(out_valid), 1);
    chk(longint'(out_phase) < MODL, "R6", "phase in range", longint'(out_phase), MODL - 1);
    if (exact) begin
      expl = c2l(s_ps);
      chk(longint'(out_phase) == expl, req, "exact start phase", longint'(out_phase), expl);
    end else begin
      expl = longint'(ref_phase(t) * 65536.0);
      d = longint'(out_phase) - expl;
      if (d < 0) d = -d;
      if (d > MODL / 2) d = MODL - d;
      chk(d <= 4, req, "interpolated phase", longint'(out_phase), expl);
    end
    @(negedge clk);
    chk(!out_valid, "R9", "single output per step", longint'(out_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid && !ld_err, "R1", "out_valid/ld_err at reset", longint'({out_valid, ld_err}), 0);
    chk(out_phase == '0, "R1", "out_phase at reset", longint'(out_phase), 0);
    chk(ld_ready && step_ready, "R1", "ready at reset", longint'({ld_ready, step_ready}), 3);
  endtask

  task automatic t_rising;
    load_seg(100.0, 300.5, 1000, 5000, 1'b0, 1'b0, 1'b0, "R2");
    step_at(1000, "R10", 1'b1);
    step_at(2000, "R2", 1'b0);
    step_at(4321, "R2", 1'b0);
    step_at(5000, "R2", 1'b0);
  endtask

  task automatic t_falling;
    load_seg(800.0, 200.25, 0, 3000, 1'b0, 1'b0, 1'b0, "R2");
    step_at(750, "R2", 1'b0);
    step_at(2999, "R2", 1'b0);
  endtask

  task automatic t_overflow;
    load_seg(1000.0, 20.0, 10, 1010, 1'b1, 1'b0, 1'b0, "R3");
    step_at(510, "R3", 1'b0);
    step_at(1000, "R3", 1'b0);
    step_at(1010, "R6", 1'b0);
  endtask

  task automatic t_underflow;
    load_seg(10.0, 1015.0, 0, 2000, 1'b0, 1'b1, 1'b0, "R4");
    step_at(400, "R4", 1'b0);
    step_at(1500, "R4", 1'b0);
    step_at(2000, "R6", 1'b0);
  endtask

  task automatic t_ignored_flags;
    load_seg(100.0, 200.0, 0, 1000, 1'b1, 1'b0, 1'b0, "R5");
    step_at(500, "R5", 1'b0);
    load_seg(600.0, 400.0, 0, 1000, 1'b0, 1'b1, 1'b0, "R5");
    step_at(250, "R5", 1'b0);
  endtask

  task automatic t_bad_loads;
    // active segment is the falling one from t_ignored_flags
    load_seg(10.0, 20.0, 50, 50, 1'b0, 1'b0, 1'b1, "R7");
    load_seg(10.0, 20.0, 50, 40, 1'b0, 1'b0, 1'b1, "R7");
    load_seg(10.0, 20.0, 0, 100, 1'b1, 1'b1, 1'b1, "R7");
    load_seg(1023.0, 20.0, 0, 100, 1'b0, 1'b0, 1'b1, "R7");
    load_seg(5.0, 1023.5, 0, 100, 1'b0, 1'b0, 1'b1, "R7");
    chk(ld_ready, "R7", "ready kept after bad loads", longint'(ld_ready), 1);
    step_at(750, "R7", 1'b0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    ld_valid = 1'b1;
    ld_phase_start = 26'(c2l(50.0));
    ld_phase_end = 26'(c2l(60.0));
    ld_time_start = 32'd0;
    ld_time_end = 32'd100;
    ld_cross_up = 1'b0;
    ld_cross_down = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    step_valid = 1'b1;
    step_time = 32'd10;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R9", "no output for refused step", longint'(out_valid), 0);
    end
    step_valid = 1'b0;
    while (!ld_ready) @(negedge clk);
    s_ps = 50.0; s_pe = 60.0; s_ts = 0; s_te = 100; s_up = 1'b0; s_dn = 1'b0;
    step_at(30, "R2", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rising();
    t_falling();
    t_overflow();
    t_underflow();
    t_ignored_flags();
    t_bad_loads();
    t_stall();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule